// File: doc/BRIEF.md
# SPI FIFO Trigger and Interrupt Unit

This block sits between a processor bus and the serial shift engine of an SPI controller. It owns two FIFOs: a transmit FIFO that the bus fills and the shift engine drains, and a receive FIFO that the shift engine fills and the bus drains. From the fill level of each FIFO it derives a request condition. That condition is compared against a programmable threshold for each direction and can drive either an interrupt or a DMA request strobe.

Software controls the unit through four word registers, selected by a 2-bit address:

- Address 0 is the FIFO control word. It holds the flush pulses, the DMA enables and the two threshold fields.
- Address 1 holds the interrupt enables.
- Address 2 is the sticky status, which is cleared by writing ones.
- Address 3 is a read-only view of both fill levels.

The shift engine reports the end of a transfer with a one-cycle pulse. That pulse is latched as a completion flag.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: In reset, the registers read as follows. Address 0 reads the receive threshold (3/4 of the depth, 12 by default) in bits 8 and up, the transmit threshold (1/4 of the depth, 4 by default) in bits 16 and up, and zero elsewhere. Addresses 1, 2 and 3 read zero. `irq`, `rxDmaReq` and `txDmaReq` are low.
- R2: Each FIFO returns words in the order they were pushed. The head word is visible on `engTxData` or `busRxData` before the pop. A push to a full FIFO and a pop from an empty one leave the fill level unchanged. Address 3 shows the receive level in bits 0 and up and the transmit level in bits 16 and up.
- R3: Writing address 0 with bit 0 set empties the receive FIFO, and with bit 1 set empties the transmit FIFO. Both may be set in one write. These two bits always read back as zero.
- R4: Status bit 0 (receive ready) is set on every cycle in which the receive level is at or above the receive threshold.
- R5: Status bit 1 (transmit request) is set on every cycle in which the transmit level is at or below the transmit threshold.
- R6: A one-cycle `xferDone` pulse sets status bit 2 (transfer complete). The bit stays set until software clears it.
- R7: Writing address 2 clears each status bit written as 1 and leaves the bits written as 0 unchanged. A bit whose set condition holds in the same cycle stays set. Writing all ones clears every flag whose condition is inactive.
- R8: `irq` is high exactly when some status bit and its enable bit in address 1 (same bit positions) are both set. Writing zero to address 1 masks all sources.
- R9: Address 0 bit 2 enables `rxDmaReq`, and bit 3 independently enables `txDmaReq`. An enabled request follows the live threshold comparison of its direction. It is unaffected by the interrupt enables and by clearing the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| busTxPush | input | 1 | Bus pushes a word into the transmit FIFO |
| busTxData | input | DATA_W | Word pushed by the bus |
| busRxPop | input | 1 | Bus pops the receive FIFO head |
| busRxData | output | DATA_W | Receive FIFO head word |
| engTxPop | input | 1 | Shift engine pops the transmit FIFO head |
| engTxData | output | DATA_W | Transmit FIFO head word |
| engRxPush | input | 1 | Shift engine pushes a received word |
| engRxData | input | DATA_W | Word pushed by the shift engine |
| xferDone | input | 1 | Transfer-complete pulse from the shift engine |
| irq | output | 1 | Interrupt request |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
The vector sequence walks the fill levels across both thresholds in each direction, so that a stuck, inverted or off-by-one comparison shows in the status word. Clears are issued both while a condition is active and after it has lapsed, which separates sticky behaviour from level-following behaviour. Enable and DMA settings are changed while the status is held fixed, which shows that masking acts only on `irq` and that the DMA lines ignore the interrupt mask. Directed runs then fill the transmit FIFO to capacity and beyond, drain it, pop it while empty, and stream receive words, to expose ordering and overflow faults.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  // Register selects
  localparam logic [1:0] ADDR_CTL   = 2'd0;
  localparam logic [1:0] ADDR_INTEN = 2'd1;
  localparam logic [1:0] ADDR_STA   = 2'd2;
  localparam logic [1:0] ADDR_LVL   = 2'd3;

  // Control word bit positions
  localparam int CTL_RX_FLUSH = 0;
  localparam int CTL_TX_FLUSH = 1;
  localparam int CTL_RX_DMA   = 2;
  localparam int CTL_TX_DMA   = 3;
  localparam int CTL_RX_TRIG  = 8;
  localparam int CTL_TX_TRIG  = 16;

  // Status / enable bit positions
  localparam int STA_RX   = 0;
  localparam int STA_TX   = 1;
  localparam int STA_DONE = 2;
  localparam int STA_W    = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic rxFlush;
    logic txFlush;
  } fifoCmd_t;

endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] popData,
  output logic [LVL_W-1:0]  level
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              doPush, doPop;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign doPush  = push && (level != FULL_LVL);
  assign doPop   = pop && (level != '0);
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= advance(wrPtr);
      if (doPop)  rdPtr <= advance(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_LVL);

  assert_full_push_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !flush && level == FULL_LVL) |=> (level == FULL_LVL));

  assert_empty_pop_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && !flush && level == '0) |=> (level == '0));

  assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (level == '0));

endmodule

// File: rtl/sfi_datapath.sv
module sfi_datapath
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic              busTxPush,
  input  logic [DATA_W-1:0] busTxData,
  input  logic              engTxPop,
  output logic [DATA_W-1:0] engTxData,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxData,
  input  logic              busRxPop,
  output logic [DATA_W-1:0] busRxData,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel
);

  // Transmit direction: bus writes, shift engine reads
  sfi_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (cmd.txFlush),
    .push     (busTxPush),
    .pushData (busTxData),
    .pop      (engTxPop),
    .popData  (engTxData),
    .level    (txLevel)
  );

  // Receive direction: shift engine writes, bus reads
  sfi_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (cmd.rxFlush),
    .push     (engRxPush),
    .pushData (engRxData),
    .pop      (busRxPop),
    .popData  (busRxData),
    .level    (rxLevel)
  );

endmodule

// File: rtl/sfi_control.sv
module sfi_control
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam logic [LVL_W-1:0] RX_TRIG_RST = LVL_W'(DEPTH / 4 * 3),
  localparam logic [LVL_W-1:0] TX_TRIG_RST = LVL_W'(DEPTH / 4)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrite,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             xferDone,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  output fifoCmd_t         cmd,
  output logic             irq,
  output logic             rxDmaReq,
  output logic             txDmaReq
);

  // Threshold fields are 8 bits wide in the word; LVL_W must not exceed 8.
  logic [LVL_W-1:0] rxTrig, txTrig;
  logic             rxDmaEn, txDmaEn;
  logic [STA_W-1:0] intEn, staReg, staSet, staClr;
  logic             rxCond, txCond;
  logic             wrCtl, wrEn, wrSta;

  assign wrCtl = regWrite && (regAddr == ADDR_CTL);
  assign wrEn  = regWrite && (regAddr == ADDR_INTEN);
  assign wrSta = regWrite && (regAddr == ADDR_STA);

  // Flush strobes last exactly the write cycle
  assign cmd.rxFlush = wrCtl && regWdata[CTL_RX_FLUSH];
  assign cmd.txFlush = wrCtl && regWdata[CTL_TX_FLUSH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxTrig  <= RX_TRIG_RST;
      txTrig  <= TX_TRIG_RST;
      rxDmaEn <= 1'b0;
      txDmaEn <= 1'b0;
    end else if (wrCtl) begin
      rxTrig  <= regWdata[CTL_RX_TRIG +: LVL_W];
      txTrig  <= regWdata[CTL_TX_TRIG +: LVL_W];
      rxDmaEn <= regWdata[CTL_RX_DMA];
      txDmaEn <= regWdata[CTL_TX_DMA];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     intEn <= '0;
    else if (wrEn) intEn <= regWdata[STA_W-1:0];
  end

  // Threshold comparisons
  assign rxCond = (rxLevel >= rxTrig);
  assign txCond = (txLevel <= txTrig);

  always_comb begin
    staSet           = '0;
    staSet[STA_RX]   = rxCond;
    staSet[STA_TX]   = txCond;
    staSet[STA_DONE] = xferDone;
    staClr           = wrSta ? regWdata[STA_W-1:0] : '0;
  end

  // Setting wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rstN) staReg <= '0;
    else       staReg <= (staReg & ~staClr) | staSet;
  end

  assign irq      = |(staReg & intEn);
  assign rxDmaReq = rxDmaEn && rxCond;
  assign txDmaReq = txDmaEn && txCond;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTL: begin
        regRdata[CTL_RX_DMA]            = rxDmaEn;
        regRdata[CTL_TX_DMA]            = txDmaEn;
        regRdata[CTL_RX_TRIG +: LVL_W]  = rxTrig;
        regRdata[CTL_TX_TRIG +: LVL_W]  = txTrig;
      end
      ADDR_INTEN: regRdata[STA_W-1:0] = intEn;
      ADDR_STA:   regRdata[STA_W-1:0] = staReg;
      default: begin
        regRdata[0 +: LVL_W]  = rxLevel;
        regRdata[16 +: LVL_W] = txLevel;
      end
    endcase
  end

  assert_rx_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel >= rxTrig) |=> staReg[STA_RX]);

  assert_tx_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= txTrig) |=> staReg[STA_TX]);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (staReg[STA_DONE] && !(wrSta && regWdata[STA_DONE])) |=> staReg[STA_DONE]);

  assert_w1c_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrSta && regWdata[STA_DONE] && !xferDone) |=> !staReg[STA_DONE]);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intEn == '0) |-> !irq);

  assert_dma_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!rxDmaEn |-> !rxDmaReq) and (!txDmaEn |-> !txDmaReq));

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              busTxPush,
  input  logic [DATA_W-1:0] busTxData,
  input  logic              busRxPop,
  output logic [DATA_W-1:0] busRxData,
  input  logic              engTxPop,
  output logic [DATA_W-1:0] engTxData,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxData,
  input  logic              xferDone,
  output logic              irq,
  output logic              rxDmaReq,
  output logic              txDmaReq
);

  fifoCmd_t         cmd;
  logic [LVL_W-1:0] txLevel, rxLevel;

  sfi_control #(.DEPTH(DEPTH)) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .xferDone (xferDone),
    .rxLevel  (rxLevel),
    .txLevel  (txLevel),
    .cmd      (cmd),
    .irq      (irq),
    .rxDmaReq (rxDmaReq),
    .txDmaReq (txDmaReq)
  );

  sfi_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .busTxPush (busTxPush),
    .busTxData (busTxData),
    .engTxPop  (engTxPop),
    .engTxData (engTxData),
    .engRxPush (engRxPush),
    .engRxData (engRxData),
    .busRxPop  (busRxPop),
    .busRxData (busRxData),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel)
  );

endmodule

// File: tb/test_spi_fifo_irq_unit.sv
module test_spi_fifo_irq_unit;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrite = 1'b0;
  logic [1:0]        regAddr = 2'd0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic              busTxPush = 1'b0;
  logic [DATA_W-1:0] busTxData = '0;
  logic              busRxPop = 1'b0;
  logic [DATA_W-1:0] busRxData;
  logic              engTxPop = 1'b0;
  logic [DATA_W-1:0] engTxData;
  logic              engRxPush = 1'b0;
  logic [DATA_W-1:0] engRxData = '0;
  logic              xferDone = 1'b0;
  logic              irq, rxDmaReq, txDmaReq;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  spi_fifo_irq_unit #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_spi_fifo_irq_unit (.*);

  // Commands: 0..2 write address 0..2, 3 bus TX push, 4 engine RX push,
  // 5 engine TX pop, 6 bus RX pop, 7 transfer-done pulse
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] arg;
    logic [2:0]  sta;
    logic        expIrq;
    logic        expRxDma;
    logic        expTxDma;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 32'h0000_0007, 3'b010, 1'b1, 1'b0, 1'b0}, // R8 enable all
    '{3'd2, 32'h0000_0007, 3'b010, 1'b1, 1'b0, 1'b0}, // R7 tx cond holds
    '{3'd0, 32'h0001_020C, 3'b010, 1'b1, 1'b0, 1'b1}, // R9 trig rx2 tx1, dma on
    '{3'd3, 32'h0000_00A1, 3'b010, 1'b1, 1'b0, 1'b1}, // R5 tx lvl 1
    '{3'd3, 32'h0000_00B2, 3'b010, 1'b1, 1'b0, 1'b0}, // R5 tx lvl 2, sticky
    '{3'd2, 32'h0000_0002, 3'b000, 1'b0, 1'b0, 1'b0}, // R7 clear tx
    '{3'd4, 32'h0000_0011, 3'b000, 1'b0, 1'b0, 1'b0}, // R4 rx lvl 1
    '{3'd4, 32'h0000_0022, 3'b001, 1'b1, 1'b1, 1'b0}, // R4 rx lvl 2
    '{3'd1, 32'h0000_0004, 3'b001, 1'b0, 1'b1, 1'b0}, // R8 R9 only done enabled
    '{3'd7, 32'h0000_0000, 3'b101, 1'b1, 1'b1, 1'b0}, // R6 done pulse
    '{3'd2, 32'h0000_0004, 3'b001, 1'b0, 1'b1, 1'b0}, // R7 clear done
    '{3'd2, 32'h0000_0001, 3'b001, 1'b0, 1'b1, 1'b0}, // R7 rx cond holds
    '{3'd6, 32'h0000_0000, 3'b001, 1'b0, 1'b0, 1'b0}, // R4 rx lvl 1 sticky
    '{3'd2, 32'h0000_0001, 3'b000, 1'b0, 1'b0, 1'b0}, // R7 clear rx
    '{3'd0, 32'h0001_0100, 3'b001, 1'b0, 1'b0, 1'b0}, // R9 dma off, rx trig 1
    '{3'd1, 32'h0000_0000, 3'b001, 1'b0, 1'b0, 1'b0}, // R8 mask all
    '{3'd1, 32'h0000_0001, 3'b001, 1'b1, 1'b0, 1'b0}, // R8 enable rx
    '{3'd0, 32'h0001_0103, 3'b011, 1'b1, 1'b0, 1'b0}, // R3 flush both
    '{3'd2, 32'hFFFF_FFFF, 3'b010, 1'b0, 1'b0, 1'b0}  // R7 clear all ones
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  // Apply one command, then one idle cycle; returns at a falling edge
  task automatic doOp(input logic [2:0] op, input logic [31:0] arg);
    @(negedge clk);
    case (op)
      3'd0, 3'd1, 3'd2: begin regWrite = 1'b1; regAddr = op[1:0]; regWdata = arg; end
      3'd3: begin busTxPush = 1'b1; busTxData = arg[DATA_W-1:0]; end
      3'd4: begin engRxPush = 1'b1; engRxData = arg[DATA_W-1:0]; end
      3'd5: engTxPop = 1'b1;
      3'd6: busRxPop = 1'b1;
      default: xferDone = 1'b1;
    endcase
    @(negedge clk);
    regWrite = 1'b0; busTxPush = 1'b0; engRxPush = 1'b0;
    engTxPop = 1'b0; busRxPop = 1'b0; xferDone = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    // R1: reset state, observed while reset is held
    repeat (3) @(negedge clk);
    readReg(2'd0, d); check("R1 ctl", d, 32'h0004_0C00);
    readReg(2'd1, d); check("R1 inten", d, 32'h0);
    readReg(2'd2, d); check("R1 status", d, 32'h0);
    readReg(2'd3, d); check("R1 levels", d, 32'h0);
    check("R1 outputs", {29'd0, irq, rxDmaReq, txDmaReq}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    readReg(2'd2, d); check("R5 empty tx after reset", d, 32'h2);

    for (int i = 0; i < NV; i++) begin
      doOp(VECS[i].op, VECS[i].arg);
      readReg(2'd2, d);
      check($sformatf("R4-R9 vector %0d status", i), d, {29'd0, VECS[i].sta});
      check($sformatf("R8 R9 vector %0d outputs", i), {29'd0, irq, rxDmaReq, txDmaReq},
            {29'd0, VECS[i].expIrq, VECS[i].expRxDma, VECS[i].expTxDma});
    end

    // R2: fill TX past capacity, then drain in order
    for (int i = 0; i < DEPTH + 1; i++) doOp(3'd3, 32'h30 + i);
    readReg(2'd3, d); check("R2 tx full level", d, 32'h0010_0000);
    for (int i = 0; i < DEPTH; i++) begin
      check("R2 tx order", {24'd0, engTxData}, 32'h30 + i);
      doOp(3'd5, 0);
    end
    doOp(3'd5, 0);
    readReg(2'd3, d); check("R2 tx pop empty", d, 32'h0);

    // R2: RX stream read by the bus
    for (int i = 0; i < 3; i++) doOp(3'd4, 32'h5A + i);
    readReg(2'd3, d); check("R2 rx level", d, 32'h0000_0003);
    for (int i = 0; i < 3; i++) begin
      check("R2 rx order", {24'd0, busRxData}, 32'h5A + i);
      doOp(3'd6, 0);
    end

    // R3: flush both FIFOs in one write, flush bits read as zero
    doOp(3'd3, 32'h77); doOp(3'd3, 32'h78);
    doOp(3'd4, 32'h66);
    readReg(2'd3, d); check("R3 pre-flush levels", d, 32'h0002_0001);
    doOp(3'd0, 32'h0001_0103);
    readReg(2'd3, d); check("R3 levels after flush", d, 32'h0);
    readReg(2'd0, d); check("R3 flush bits self-clear", d, 32'h0001_0100);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule